// File: doc/BRIEF.md
# CAN Bus Wake-Up Pattern Detector

This block watches one CAN channel while that channel sits in its low-power standby mode and decides when traffic on the bus should wake the node. A low-power comparator outside the block turns the bus into one bit, dominant or recessive. That bit reaches the block with no timing relation to the clock, so the block first passes it through a two-flop synchroniser. It then measures how long each level stays stable. A level counts as a phase only after it has held for a programmable number of clock cycles.

A wake is recognised when three qualified phases arrive in order: dominant, then recessive, then dominant. All of them must fall inside a timeout window. The window opens at the moment the first dominant phase qualifies. If the window closes before the pattern is complete, the search starts again from the beginning. Until a wake is found, the receive-data output stays high. Once a wake is confirmed, that output follows the synchronised bus: low for dominant, high for recessive. A one-cycle pulse marks the moment of detection, and a level flag holds the awake state until the channel leaves standby. Leaving standby clears all detection state.

Top module: `can_wake_detect`

## Requirements
- R1: After reset, with standby asserted and a recessive bus, `rxd_o` is 1, `wake_o` is 0 and `wake_pulse_o` is 0.
- R2: A bus level (1 = dominant on `bus_dom_i`) held for fewer than FILT_CYC clock cycles is not a phase. A dominant glitch of FILT_CYC-1 cycles does not start the pattern.
- R3: A dominant phase, then a recessive phase, then a dominant phase, each held at least FILT_CYC cycles, raise `wake_pulse_o`. The pulse is seen in the cycle FILT_CYC+3 clock edges after the final dominant phase is driven.
- R4: `wake_pulse_o` is high for exactly one cycle per detection. `wake_o` rises with it and stays high while standby remains asserted.
- R5: Let D1 be the length of the first dominant phase and R the length of the recessive phase, both in cycles. A wake occurs only if D1 + R < WAKE_TO_CYC. When D1 + R = WAKE_TO_CYC, the window expires first and the search restarts. A dominant phase that is still present is then taken as a new first phase.
- R6: After a wake, `rxd_o` equals the inverse of `bus_dom_i`, delayed by two clock edges.
- R7: With `standby_i` low, the block is idle. One edge after standby drops, `wake_o` is 0 and `rxd_o` is 1, and no bus pattern in normal mode produces a wake pulse.
- R8: While the block waits for the recessive phase, a recessive gap shorter than FILT_CYC cycles inside a dominant stretch does not count as that phase.
- R9: Before a wake, `rxd_o` stays 1 even while the bus is dominant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_i | input | 1 | 1 = channel in standby; detector active |
| bus_dom_i | input | 1 | Asynchronous bus state from the low-power comparator, 1 = dominant |
| rxd_o | output | 1 | Receive data: 1 before a wake, inverse of the bus after one |
| wake_o | output | 1 | Held high once a wake is detected, until standby is left |
| wake_pulse_o | output | 1 | One-cycle pulse at detection |

## Verification
The assertions assume `standby_i` changes synchronously to the clock, and they assume that reset is held for at least one edge before any pattern begins. Only the bus input is treated as asynchronous. The stimulus changes both the bus and the standby input only on the falling clock edge. Every phase length, and every sum of phase lengths, is chosen as an exact number of cycles, so each boundary falls on a known clock edge. The bench runs with small filter and timeout values, so the boundaries at FILT_CYC-1 and at WAKE_TO_CYC are reached within a short run.

// File: rtl/wk_pkg.sv
package wk_pkg;

    typedef enum logic [1:0] {
        WK_IDLE     = 2'd0,
        WK_SEEK_REC = 2'd1,
        WK_SEEK_DOM = 2'd2,
        WK_AWAKE    = 2'd3
    } wk_state_e;

    typedef struct packed {
        logic dom;
        logic rec;
    } wk_qual_t;

    function automatic int wk_cnt_w(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

    function automatic logic wk_searching(input wk_state_e s);
        return (s == WK_SEEK_REC) || (s == WK_SEEK_DOM);
    endfunction

endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wk_phase_filter.sv
module wk_phase_filter
    import wk_pkg::*;
#(
    parameter int FILT_CYC = 50
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clr_i,
    input  logic     lvl_i,
    output wk_qual_t qual_o
);
    localparam int CW = wk_cnt_w(FILT_CYC);
    localparam logic [CW-1:0] LIMIT = CW'(FILT_CYC);

    logic          lvl_q;
    logic [CW-1:0] run_q;
    logic          held;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            lvl_q <= 1'b0;
            run_q <= '0;
        end else if (lvl_i != lvl_q) begin
            lvl_q <= lvl_i;
            run_q <= CW'(1);
        end else if (run_q != LIMIT) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign held       = (run_q == LIMIT);
    assign qual_o.dom = held && lvl_q;
    assign qual_o.rec = held && !lvl_q;

    p_run_bound_r2: assert property (@(posedge clk) disable iff (rst)
        run_q <= LIMIT);

    p_qual_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
        !(qual_o.dom && qual_o.rec));

endmodule

// File: rtl/wk_window.sv
module wk_window #(
    parameter int WAKE_TO_CYC = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = (WAKE_TO_CYC < 2) ? 1 : $clog2(WAKE_TO_CYC);
    localparam logic [CW-1:0] LAST = CW'(WAKE_TO_CYC - 1);

    logic [CW-1:0] age_q;

    assign expired_o = run_i && (age_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            age_q <= '0;
        end else if (!expired_o) begin
            age_q <= age_q + 1'b1;
        end
    end

    p_age_bound_r5: assert property (@(posedge clk) disable iff (rst)
        age_q <= LAST);

endmodule

// File: rtl/can_wake_detect.sv
module can_wake_detect
    import wk_pkg::*;
#(
    parameter int FILT_CYC    = 50,
    parameter int WAKE_TO_CYC = 50000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic standby_i,
    input  logic bus_dom_i,
    output logic rxd_o,
    output logic wake_o,
    output logic wake_pulse_o
);
    wk_state_e st_q, st_d;
    wk_qual_t  qual;
    logic      bus_s;
    logic      win_run;
    logic      win_expired;
    logic      pulse_q;

    wk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (bus_dom_i),
        .q_o (bus_s)
    );

    wk_phase_filter #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (!standby_i),
        .lvl_i  (bus_s),
        .qual_o (qual)
    );

    assign win_run = standby_i && wk_searching(st_q);

    wk_window #(.WAKE_TO_CYC(WAKE_TO_CYC)) u_win (
        .clk       (clk),
        .rst       (rst),
        .run_i     (win_run),
        .expired_o (win_expired)
    );

    always_comb begin
        st_d = st_q;
        if (!standby_i) begin
            st_d = WK_IDLE;
        end else if (win_expired) begin
            st_d = WK_IDLE;
        end else begin
            unique case (st_q)
                WK_IDLE:     if (qual.dom) st_d = WK_SEEK_REC;
                WK_SEEK_REC: if (qual.rec) st_d = WK_SEEK_DOM;
                WK_SEEK_DOM: if (qual.dom) st_d = WK_AWAKE;
                WK_AWAKE:    st_d = WK_AWAKE;
                default:     st_d = WK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= WK_IDLE;
            pulse_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            pulse_q <= (st_d == WK_AWAKE) && (st_q != WK_AWAKE);
        end
    end

    assign wake_o       = (st_q == WK_AWAKE);
    assign wake_pulse_o = pulse_q;
    assign rxd_o        = !(wake_o && bus_s);

    p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
        wake_pulse_o |=> !wake_pulse_o);

    p_wake_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (wake_o && standby_i) |=> wake_o);

    p_rise_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_o) |-> wake_pulse_o);

    p_normal_clear_r7: assert property (@(posedge clk) disable iff (rst)
        !standby_i |=> (!wake_o && rxd_o));

    p_start_needs_dom_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == WK_SEEK_REC && $past(st_q) == WK_IDLE) |-> $past(qual.dom));

    p_mid_needs_rec_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q == WK_SEEK_DOM && $past(st_q) == WK_SEEK_REC) |-> $past(qual.rec));

    p_idle_rxd_high_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q != WK_AWAKE) |-> rxd_o);

endmodule

// File: tb/tb_can_wake_detect.sv
module tb_can_wake_detect;
    localparam int F  = 4;
    localparam int TO = 60;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic standby = 1'b1;
    logic bus_dom = 1'b0;
    logic rxd, wake, wake_pulse;

    int cyc = 0;
    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;
    int exp_q[$];

    can_wake_detect #(.FILT_CYC(F), .WAKE_TO_CYC(TO)) dut (
        .clk          (clk),
        .rst          (rst),
        .standby_i    (standby),
        .bus_dom_i    (bus_dom),
        .rxd_o        (rxd),
        .wake_o       (wake),
        .wake_pulse_o (wake_pulse)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    // Scoreboard monitor: each pulse is matched against the expected cycle (R3, R5)
    always @(negedge clk) begin
        if (!rst) begin
            if (exp_q.size() > 0 && exp_q[0] < cyc) begin
                chk(1'b0, "R3 missing wake pulse", cyc, exp_q[0]);
                void'(exp_q.pop_front());
            end
            if (wake_pulse) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected wake pulse", cyc, -1);
                end else begin
                    chk(exp_q[0] == cyc, "R3 pulse cycle", cyc, exp_q[0]);
                    void'(exp_q.pop_front());
                end
            end
        end
    end

    task automatic drive(input logic lvl, input int n);
        bus_dom = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic enter_standby();
        standby = 1'b0;
        bus_dom = 1'b0;
        repeat (3) @(negedge clk);
        standby = 1'b1;
        drive(1'b0, 10);
    endtask

    task automatic expect_wake_in_next(input int n);
        exp_q.push_back(cyc + F + 3);
        drive(1'b1, n);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        drive(1'b0, 10);
        // R1 reset state
        chk(rxd == 1'b1, "R1 rxd", rxd, 1);
        chk(wake == 1'b0, "R1 wake", wake, 0);
        chk(wake_pulse == 1'b0, "R1 pulse", wake_pulse, 0);

        // R2: short dominant glitch must not start the pattern
        drive(1'b1, F - 1);
        drive(1'b0, 10);
        drive(1'b1, F + 2);
        // R9: rxd stays high while bus dominant before a wake
        chk(rxd == 1'b1, "R9 rxd high on dominant bus", rxd, 1);
        drive(1'b0, 10);
        chk(wake == 1'b0, "R2 glitch ignored", wake, 0);

        // R3/R4/R6: full pattern
        enter_standby();
        drive(1'b1, 5);
        drive(1'b0, 5);
        expect_wake_in_next(F + 6);
        chk(wake == 1'b1, "R4 wake held", wake, 1);
        chk(wake_pulse == 1'b0, "R4 pulse one cycle", wake_pulse, 0);
        chk(rxd == 1'b0, "R6 rxd dominant", rxd, 0);
        bus_dom = 1'b0;
        @(negedge clk);
        chk(rxd == 1'b0, "R6 latency edge 1", rxd, 0);
        @(negedge clk);
        chk(rxd == 1'b1, "R6 latency edge 2", rxd, 1);
        bus_dom = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(rxd == 1'b0, "R6 follows dominant", rxd, 0);
        drive(1'b1, 3);
        chk(wake == 1'b1, "R4 wake still held", wake, 1);

        // R7: leaving standby clears, normal mode ignores patterns
        standby = 1'b0;
        @(negedge clk);
        chk(wake == 1'b0, "R7 wake cleared", wake, 0);
        chk(rxd == 1'b1, "R7 rxd high", rxd, 1);
        drive(1'b0, 6);
        drive(1'b1, 6);
        drive(1'b0, 6);
        drive(1'b1, 10);
        chk(wake == 1'b0, "R7 no wake in normal mode", wake, 0);
        chk(rxd == 1'b1, "R7 rxd in normal mode", rxd, 1);

        // R8: short recessive gap is not the recessive phase
        enter_standby();
        drive(1'b1, 5);
        drive(1'b0, F - 1);
        drive(1'b1, 5);
        chk(wake == 1'b0, "R8 gap not counted", wake, 0);
        drive(1'b0, 5);
        expect_wake_in_next(F + 6);
        chk(wake == 1'b1, "R8 wake after real phase", wake, 1);

        // R5: boundary D1+R = TO-1 wakes
        enter_standby();
        drive(1'b1, 5);
        drive(1'b0, TO - 1 - 5);
        expect_wake_in_next(F + 6);
        chk(wake == 1'b1, "R5 wake at TO-1", wake, 1);

        // R5: D1+R = TO times out and restarts with the next dominant
        enter_standby();
        drive(1'b1, 5);
        drive(1'b0, TO - 5);
        drive(1'b1, F + 4);
        chk(wake == 1'b0, "R5 timeout no wake", wake, 0);
        drive(1'b0, 5);
        expect_wake_in_next(F + 6);
        chk(wake == 1'b1, "R5 restart wake", wake, 1);

        drive(1'b0, 5);
        chk(exp_q.size() == 0, "R3 all pulses seen", exp_q.size(), 0);
        done = 1'b1;
        report();
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            report();
        end
    end
endmodule